// File: doc/BRIEF.md
# Shadowed InfoFrame Packet Scheduler

This block holds the payload of one video InfoFrame and decides in which frames it is sent. Software loads the payload words into staging registers through a simple write port. Those writes stay invisible to the transmit side until software sets a commit bit in the control register. The block then copies all staged words into a shadow copy at the next frame start where no packet is in flight, and clears the bit on its own. A packet built from the shadow copy is therefore never a mix of old and new words.

While sending is enabled, every frame start asks for a packet. With the reduced rate selected, only every other frame start asks, counted from the first frame start after enabling. A packet is a run of words that leaves on a valid/ready stream, lowest word first. The stream moves only while the blanking input is high. The rest of the data-island path takes the words from there.

Top module: `ifr_pkt_sched`

## Requirements
- R1: After reset, `pkt_valid_o` is 0, `ctrl_o` reads 0 (disabled, full rate, no commit pending) and every shadow word is zero, so the first packet sent without a commit is all zeros.
- R2: Address k, for k below NUM_WORDS, writes staging word k. Address NUM_WORDS is the control register: bit 0 enables sending, bit 1 selects the reduced rate and bit 2 requests a commit. A write to a staging word changes nothing that is sent until a commit has taken place.
- R3: Writing 1 to control bit 2 makes `ctrl_o[2]` read 1. At the first frame start with no packet in progress, the staged words become the shadow copy and `ctrl_o[2]` returns to 0. A packet started at that same frame start carries the new words.
- R4: A commit requested while a packet is in progress does not take place at a frame start that falls inside that packet, so the packet keeps its old words and `ctrl_o[2]` stays 1.
- R5: While control bit 0 is 0, frame starts produce no packet.
- R6: With bit 0 = 1 and bit 1 = 0, every frame start that finds the block idle starts a packet.
- R7: With bits 0 and 1 both 1, packets start on the 1st, 3rd, 5th… frame start counted from the moment the block is enabled. Disabling the block restarts that count.
- R8: A packet is NUM_WORDS words in order, word 0 first. While `pkt_ready_i` is 0, the current word and `pkt_valid_o` are held.
- R9: `pkt_valid_o` is 0 while `blank_i` is 0. A pending packet waits and resumes when `blank_i` rises.
- R10: A frame start that arrives while a packet is still in progress is dropped and causes no extra packet.
- R11: `pkt_last_o` is 1 exactly with the final word. After that word is accepted, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: staging words, then control |
| wr_data_i | input | WORD_W | Write data |
| ctrl_o | output | 3 | Control state: enable, reduced rate, commit pending |
| frame_start_i | input | 1 | One-cycle pulse at each frame boundary |
| blank_i | input | 1 | High during blanking; the stream moves only then |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_ready_i | input | 1 | Downstream accepts the word |
| pkt_data_o | output | WORD_W | Current payload word |
| pkt_last_o | output | 1 | Marks the final word of the packet |

## Verification
The bench builds the block with its defaults: 32-bit words and four words per packet. This exercises the word index wrapping from 3 and the control register sitting at address 4. These values also cover a commit deferred behind a stalled packet, the alternate-frame phase counted from a fresh enable, and a frame start dropped mid-packet. A ready line that toggles and a blanking input that drops show the hold behaviour on the stream.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_HALF = 1;
  localparam int CTRL_UPD  = 2;

  typedef struct packed {
    logic upd_pend;
    logic half_rate;
    logic enable;
  } ifr_ctrl_t;
endpackage

// File: rtl/ifr_stage.sv
module ifr_stage
  import ifr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [WORD_W-1:0]                 wr_data_i,
  input  logic                              commit_i,
  input  logic                              busy_i,
  input  logic                              frame_start_i,
  output ifr_ctrl_t                         ctrl_o,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  shadow_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);

  logic [NUM_WORDS-1:0][WORD_W-1:0] stage_q, shadow_q;
  ifr_ctrl_t ctrl_q;
  logic wr_ctrl;

  assign wr_ctrl = wr_en_i && (wr_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (wr_addr_i == ADDR_W'(i)) stage_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (commit_i) shadow_q <= stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.enable    <= wr_data_i[CTRL_EN];
        ctrl_q.half_rate <= wr_data_i[CTRL_HALF];
      end
      // a fresh request wins over a commit in the same cycle
      ctrl_q.upd_pend <= (ctrl_q.upd_pend && !commit_i) || (wr_ctrl && wr_data_i[CTRL_UPD]);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign shadow_o = shadow_q;

  assert_shadow_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shadow_q) |-> !$past(busy_i));

  assert_commit_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.upd_pend) |-> $past(frame_start_i && !busy_i));
endmodule

// File: rtl/ifr_sched.sv
module ifr_sched (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic enable_i,
  input  logic half_i,
  input  logic pend_i,
  input  logic busy_i,
  output logic start_o,
  output logic commit_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            phase_q <= 1'b0;
    else if (!enable_i)     phase_q <= 1'b0;
    else if (frame_start_i) phase_q <= ~phase_q;
  end

  assign start_o  = frame_start_i && enable_i && (!half_i || !phase_q) && !busy_i;
  assign commit_o = frame_start_i && pend_i && !busy_i;
endmodule

// File: rtl/ifr_tx.sv
module ifr_tx #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic                              blank_i,
  input  logic                              ready_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  shadow_i,
  output logic                              valid_o,
  output logic [WORD_W-1:0]                 data_o,
  output logic                              last_o,
  output logic                              busy_o
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign valid_o = busy_q && blank_i;
  assign fire    = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  assign data_o = shadow_i[idx_q];
  assign last_o = busy_q && (idx_q == LAST_IDX);
  assign busy_o = busy_q;

  assert_hold_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && blank_i |=> valid_o && $stable(data_o));

  assert_last_ends_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !busy_o);
endmodule

// File: rtl/ifr_pkt_sched.sv
module ifr_pkt_sched
  import ifr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int ADDR_W   = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [2:0]        ctrl_o,
  input  logic              frame_start_i,
  input  logic              blank_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [WORD_W-1:0] pkt_data_o,
  output logic              pkt_last_o
);
  ifr_ctrl_t ctrl;
  logic [NUM_WORDS-1:0][WORD_W-1:0] shadow;
  logic start, commit, busy;

  ifr_stage #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_stage (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .commit_i(commit), .busy_i(busy), .frame_start_i,
    .ctrl_o(ctrl), .shadow_o(shadow)
  );

  ifr_sched u_sched (
    .clk_i, .rst_ni, .frame_start_i,
    .enable_i(ctrl.enable), .half_i(ctrl.half_rate), .pend_i(ctrl.upd_pend),
    .busy_i(busy), .start_o(start), .commit_o(commit)
  );

  ifr_tx #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_tx (
    .clk_i, .rst_ni, .start_i(start), .blank_i, .ready_i(pkt_ready_i),
    .shadow_i(shadow), .valid_o(pkt_valid_o), .data_o(pkt_data_o),
    .last_o(pkt_last_o), .busy_o(busy)
  );

  assign ctrl_o = ctrl;

  assert_start_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl.enable && frame_start_i));
endmodule

// File: tb/sim_ifr_pkt_sched.sv
module sim_ifr_pkt_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  ctrl;
  logic        frame_start = 1'b0;
  logic        blank = 1'b1;
  logic        valid, last;
  logic        ready = 1'b1;
  logic [31:0] data;

  int n_chk = 0, n_fail = 0, acc_cnt = 0;
  logic [32:0] exp_q[$];
  logic        hold_on = 1'b0;
  logic [31:0] hold_data;

  always #2 clk = ~clk;

  ifr_pkt_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .frame_start_i(frame_start),
    .blank_i(blank), .pkt_valid_o(valid), .pkt_ready_i(ready),
    .pkt_data_o(data), .pkt_last_o(last)
  );

  task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(); wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  task automatic fs();
    step(); frame_start = 1'b1;
    step(); frame_start = 1'b0;
  endtask

  task automatic push_pkt(input logic [31:0] b);
    for (int i = 0; i < 4; i++) exp_q.push_back({i == 3, b + 32'(i)});
  endtask

  task automatic load(input logic [31:0] b);
    for (int i = 0; i < 4; i++) wr(3'(i), b + 32'(i));
  endtask

  // scoreboard monitor: R8 order/hold, R11 last flag
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (hold_on) chk(data == hold_data, "R8 hold", {1'b0, data}, {1'b0, hold_data});
        if (ready) begin
          acc_cnt++;
          if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", {last, data}, '0);
          else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk({last, data} == e, "R8 R11 word", {last, data}, e);
          end
          hold_on = 1'b0;
        end else begin
          hold_on   = 1'b1;
          hold_data = data;
        end
      end else hold_on = 1'b0;
    end
  end

  initial begin
    int cnt0;
    fork
      begin
        idle(3); rst_n = 1'b1; step();
        @(negedge clk);
        chk(!valid, "R1 valid", {32'b0, valid}, '0);
        chk(ctrl == 3'b000, "R1 ctrl", {30'b0, ctrl}, '0);

        // R1/R6: enabled, no commit -> zeros
        wr(3'd4, 32'h1);
        push_pkt(32'h0); exp_q[3] = {1'b1, 32'h0};
        for (int i = 0; i < 4; i++) exp_q[exp_q.size()-4+i] = {i == 3, 32'h0};
        fs(); idle(8);
        // R2: staging only
        load(32'hA000_0010);
        for (int i = 0; i < 4; i++) exp_q.push_back({i == 3, 32'h0});
        fs(); idle(8);
        chk(exp_q.size() == 0, "R2 no leak", 33'(exp_q.size()), '0);

        // R3: commit
        wr(3'd4, 32'h5);
        @(negedge clk);
        chk(ctrl[2], "R3 pending set", {30'b0, ctrl}, 33'h5);
        push_pkt(32'hA000_0010);
        fs(); idle(8);
        @(negedge clk);
        chk(ctrl == 3'b001, "R3 self clear", {30'b0, ctrl}, 33'h1);

        // R5: disabled
        wr(3'd4, 32'h0);
        fs(); @(negedge clk);
        chk(!valid, "R5 no packet", {32'b0, valid}, '0);
        fs(); idle(6);
        chk(acc_cnt == 12, "R5 word count", 33'(acc_cnt), 33'd12);

        // R7: reduced rate from fresh enable
        load(32'hB000_0100);
        wr(3'd4, 32'h7);
        cnt0 = acc_cnt;
        push_pkt(32'hB000_0100); fs(); idle(8);
        fs(); idle(8);
        push_pkt(32'hB000_0100); fs(); idle(8);
        fs(); idle(8);
        chk(acc_cnt - cnt0 == 8, "R7 alternate frames", 33'(acc_cnt - cnt0), 33'd8);

        // R6/R8/R11: full rate, ready stalls
        wr(3'd4, 32'h1);
        ready = 1'b0;
        push_pkt(32'hB000_0100); fs();
        @(negedge clk);
        chk(valid && data == 32'hB000_0100 && !last, "R8 first word", {last, data}, {1'b0, 32'hB000_0100});
        idle(3); @(negedge clk);
        chk(valid && data == 32'hB000_0100, "R8 held", {valid, data}, {1'b1, 32'hB000_0100});
        for (int i = 0; i < 10; i++) begin step(); ready = i[0]; end
        ready = 1'b1; idle(4);
        chk(exp_q.size() == 0, "R6 R8 drained", 33'(exp_q.size()), '0);

        // R9: blanking gates the stream
        blank = 1'b0;
        push_pkt(32'hB000_0100); fs();
        @(negedge clk);
        chk(!valid, "R9 gated", {32'b0, valid}, '0);
        idle(2); @(negedge clk);
        chk(!valid, "R9 still gated", {32'b0, valid}, '0);
        step(); blank = 1'b1; idle(6);
        chk(exp_q.size() == 0, "R9 resumed", 33'(exp_q.size()), '0);

        // R4/R10: commit and frame start while busy
        ready = 1'b0;
        push_pkt(32'hB000_0100); fs();
        load(32'hD000_1000);
        wr(3'd4, 32'h5);
        fs();
        @(negedge clk);
        chk(ctrl[2], "R4 commit deferred", {30'b0, ctrl}, 33'h5);
        step(); ready = 1'b1; idle(8);
        @(negedge clk);
        chk(!valid && exp_q.size() == 0, "R10 dropped", {valid, 32'(exp_q.size())}, '0);
        chk(ctrl[2], "R4 still pending", {30'b0, ctrl}, 33'h5);
        push_pkt(32'hD000_1000); fs(); idle(8);
        @(negedge clk);
        chk(ctrl == 3'b001, "R3 R4 committed", {30'b0, ctrl}, 33'h1);
        chk(exp_q.size() == 0, "R8 queue empty", 33'(exp_q.size()), '0);
      end
      begin
        idle(20000);
        chk(1'b0, "watchdog", '0, '0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule